// File: doc/BRIEF.md
# Coin Vending Controller

This block is a small sequential controller for a candy dispenser with one coin slot. A sensor ahead of it classifies each coin and raises a single-cycle pulse on either the nickel line (5 cents) or the dime line (10 cents). The controller adds the value of each accepted coin to a held credit. Once the credit reaches the price of 25 cents, it raises a vend strobe for one clock cycle. Any overpayment is kept, since the machine returns no change. After the strobe, both credit and coin count go back to zero.

The credit is held in a one-hot state register with five credit levels (0, 5, 10, 15 and 20 cents) and a separate vend state. A coin counter records how many coins make up the current purchase. A seven-segment driver shows that count as a single decimal digit. An asynchronous active-low clear returns the machine to zero credit at any time, without waiting for a clock edge.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `arst_n` is low, `vend_o` is 0 and `seg_n_o` shows digit 0 (7'b1000000). This takes effect as soon as `arst_n` falls, with no clock edge needed.
- R2: A nickel pulse adds 5 cents and a dime pulse adds 10 cents to the credit. With no pulse, the credit is held.
- R3: `vend_o` goes high in the cycle after the clock edge that samples the coin bringing the credit to 25 cents or more. A 30-cent total vends the same way a 25-cent total does.
- R4: `vend_o` stays high for exactly one cycle. In the following cycle the credit is 0 and the displayed coin count is 0.
- R5: When `nickel_i` and `dime_i` are both high in the same cycle, only the dime counts: 10 cents and one coin.
- R6: A coin pulse that arrives during the vend cycle is ignored. It adds neither credit nor count.
- R7: `seg_n_o` is active low, with bit 6 driving segment g down to bit 0 driving segment a. The digit codes are: 0=1000000, 1=1111001, 2=0100100, 3=0110000, 4=0011001, 5=0010010.
- R8: The displayed count goes up by one for each accepted coin and never exceeds 5. During the vend cycle it still shows the coins of that purchase.
- R9: The state register always holds exactly one active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous clear, active low |
| nickel_i | input | 1 | One-cycle pulse: a nickel was detected |
| dime_i | input | 1 | One-cycle pulse: a dime was detected |
| vend_o | output | 1 | One-cycle dispense strobe |
| seg_n_o | output | 7 | Active-low segments, gfedcba, showing the coin count |

## Verification
The assertions assume that each coin arrives as a pulse already synchronized to `clk`. They also assume that `arst_n` is released away from the rising edge, so that the first sampled state is zero credit.

The stimulus respects both assumptions. It changes the coin lines only on the falling edge, and it drops and raises `arst_n` between edges. It never holds a pulse for longer than the cycle it belongs to, except on purpose to probe R5 and R6.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int SEG_W = 7;

  // Active-low gfedcba pattern for a decimal digit; anything above 9 is blank.
  function automatic logic [SEG_W-1:0] seg_code_n(input logic [3:0] digit);
    logic [SEG_W-1:0] lit;
    case (digit)
      4'd0: lit = 7'h3F;
      4'd1: lit = 7'h06;
      4'd2: lit = 7'h5B;
      4'd3: lit = 7'h4F;
      4'd4: lit = 7'h66;
      4'd5: lit = 7'h6D;
      4'd6: lit = 7'h7D;
      4'd7: lit = 7'h07;
      4'd8: lit = 7'h7F;
      4'd9: lit = 7'h6F;
      default: lit = '0;
    endcase
    return ~lit;
  endfunction

  // Credit arithmetic is kept in coin units (one unit = 5 cents).
  function automatic int unsigned credit_sum(input int unsigned held,
                                             input int unsigned add);
    return held + add;
  endfunction

  function automatic logic reaches_price(input int unsigned sum,
                                         input int unsigned price);
    return sum >= price;
  endfunction

endpackage

// File: rtl/coin_arbiter.sv
module coin_arbiter #(
  parameter int NICKEL_UNITS = 1,
  parameter int DIME_UNITS   = 2,
  parameter int UNIT_W       = 3
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              nickel_i,
  input  logic              dime_i,
  input  logic              busy_i,
  output logic              take_o,
  output logic [UNIT_W-1:0] units_o
);

  logic take_dime;
  logic take_nickel;

  // Dime wins a same-cycle collision; nothing is taken while vending.
  assign take_dime   = dime_i & ~busy_i;
  assign take_nickel = nickel_i & ~dime_i & ~busy_i;
  assign take_o      = take_dime | take_nickel;

  always_comb begin
    units_o = '0;
    if (take_dime)        units_o = UNIT_W'(DIME_UNITS);
    else if (take_nickel) units_o = UNIT_W'(NICKEL_UNITS);
  end

  // R5
  both_pick_dime_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (nickel_i && dime_i && !busy_i) |-> (units_o == UNIT_W'(DIME_UNITS)));

  // R6
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!arst_n)
    busy_i |-> (!take_o && units_o == '0));

endmodule

// File: rtl/credit_fsm.sv
module credit_fsm
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS = 5,
  parameter int UNIT_W      = 3
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              take_i,
  input  logic [UNIT_W-1:0] units_i,
  output logic              vend_o
);

  localparam int NS     = PRICE_UNITS + 1;
  localparam int VEND_B = NS - 1;

  logic [NS-1:0]          state_q;
  logic [NS-1:0]          state_d;
  logic [UNIT_W-1:0]      held_w;
  logic [UNIT_W-1:0]      sum_w;
  logic                   over_w;
  logic [PRICE_UNITS-1:0] hit_w;

  // Credit level of the active one-hot bit, in coin units.
  always_comb begin
    held_w = '0;
    for (int i = 1; i < PRICE_UNITS; i++)
      if (state_q[i]) held_w = UNIT_W'(i);
  end

  assign sum_w  = UNIT_W'(credit_sum(int'(held_w), int'(units_i)));
  assign over_w = reaches_price(int'(sum_w), PRICE_UNITS);

  genvar g;
  generate
    for (g = 0; g < PRICE_UNITS; g++) begin : g_lvl
      assign hit_w[g] = (sum_w == UNIT_W'(g));
      if (g == 0) begin : g_home
        assign state_d[g] = state_q[VEND_B] | (~take_i & state_q[g]);
      end else begin : g_mid
        assign state_d[g] = ~state_q[VEND_B] &
                            (take_i ? hit_w[g] : state_q[g]);
      end
    end
  endgenerate

  assign state_d[VEND_B] = ~state_q[VEND_B] & take_i & over_w;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= NS'(1);
    else         state_q <= state_d;
  end

  assign vend_o = state_q[VEND_B];

  // R9
  one_hot_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $countones(state_q) == 1);

  // R4
  vend_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    vend_o |=> !vend_o);

  // R4
  vend_home_chk: assert property (@(posedge clk) disable iff (!arst_n)
    vend_o |=> state_q[0]);

  // R2
  credit_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!take_i && !vend_o) |=> $stable(state_q));

  // R3
  top_level_vend_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (take_i && state_q[PRICE_UNITS-1]) |=> vend_o);

endmodule

// File: rtl/coin_counter.sv
module coin_counter #(
  parameter int MAX_COINS = 5,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             take_i,
  input  logic             vend_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     count_q <= '0;
    else if (vend_i) count_q <= '0;
    else if (take_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (take_i && !vend_i) |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
    count_q <= CNT_W'(MAX_COINS));

  // R4
  count_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    vend_i |=> (count_q == '0));

endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
  import vend_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int MAX_COINS = 5
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [CNT_W-1:0] count_i,
  output logic [SEG_W-1:0] seg_n_o
);

  assign seg_n_o = seg_code_n(4'(count_i));

  // R7
  digit_lit_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (count_i <= CNT_W'(MAX_COINS)) |-> (seg_n_o != '1 && seg_n_o != '0));

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter int PRICE_UNITS  = 5,
  parameter int NICKEL_UNITS = 1,
  parameter int DIME_UNITS   = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             nickel_i,
  input  logic             dime_i,
  output logic             vend_o,
  output logic [SEG_W-1:0] seg_n_o
);

  localparam int UNIT_W    = $clog2(PRICE_UNITS + DIME_UNITS + 1);
  localparam int MAX_COINS = (PRICE_UNITS + NICKEL_UNITS - 1) / NICKEL_UNITS;
  localparam int CNT_W     = $clog2(MAX_COINS + 1);

  logic              coin_take;
  logic [UNIT_W-1:0] coin_units;
  logic              vend_state;
  logic [CNT_W-1:0]  coin_count;

  coin_arbiter #(
    .NICKEL_UNITS(NICKEL_UNITS),
    .DIME_UNITS  (DIME_UNITS),
    .UNIT_W      (UNIT_W)
  ) u_arbiter (
    .clk     (clk),
    .arst_n  (arst_n),
    .nickel_i(nickel_i),
    .dime_i  (dime_i),
    .busy_i  (vend_state),
    .take_o  (coin_take),
    .units_o (coin_units)
  );

  credit_fsm #(
    .PRICE_UNITS(PRICE_UNITS),
    .UNIT_W     (UNIT_W)
  ) u_fsm (
    .clk    (clk),
    .arst_n (arst_n),
    .take_i (coin_take),
    .units_i(coin_units),
    .vend_o (vend_state)
  );

  coin_counter #(
    .MAX_COINS(MAX_COINS),
    .CNT_W    (CNT_W)
  ) u_counter (
    .clk    (clk),
    .arst_n (arst_n),
    .take_i (coin_take),
    .vend_i (vend_state),
    .count_o(coin_count)
  );

  seg_encoder #(
    .CNT_W    (CNT_W),
    .MAX_COINS(MAX_COINS)
  ) u_seg (
    .clk    (clk),
    .arst_n (arst_n),
    .count_i(coin_count),
    .seg_n_o(seg_n_o)
  );

  assign vend_o = vend_state;

endmodule

// File: tb/test_coin_vend_ctrl.sv
module test_coin_vend_ctrl;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       nickel = 1'b0;
  logic       dime = 1'b0;
  logic       vend;
  logic [6:0] seg;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int exp_cents = 0;
  int exp_coins = 0;
  bit exp_vend = 0;

  coin_vend_ctrl i_coin_vend_ctrl (
    .clk     (clk),
    .arst_n  (arst_n),
    .nickel_i(nickel),
    .dime_i  (dime),
    .vend_o  (vend),
    .seg_n_o (seg)
  );

  always #4 clk = ~clk;

  // Active-low gfedcba patterns as stated in R7.
  function automatic logic [6:0] digit_pattern(input int d);
    case (d)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      default: return 7'b1111111;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(vend === exp_vend, tag, "vend", int'(vend), int'(exp_vend));
    check(seg === digit_pattern(exp_coins), tag, "seg", int'(seg),
          int'(digit_pattern(exp_coins)));
  endtask

  // One cycle: drive at a falling edge, sampled on the rising edge,
  // outputs compared at the next falling edge.
  task automatic step(input bit n, input bit d, input string tag);
    nickel = n;
    dime = d;
    @(negedge clk);
    nickel = 1'b0;
    dime = 1'b0;
    if (exp_vend) begin
      exp_vend = 0;
      exp_cents = 0;
      exp_coins = 0;
    end else if (n || d) begin
      exp_cents += d ? 10 : 5;
      exp_coins++;
      if (exp_cents >= 25) exp_vend = 1;
    end
    compare(tag);
  endtask

  task automatic t_clear(input string tag);
    #1 arst_n = 1'b0;
    #1;
    exp_vend = 0;
    exp_cents = 0;
    exp_coins = 0;
    compare(tag);
    @(negedge clk);
    arst_n = 1'b1;
  endtask

  task automatic t_five_nickels();
    for (int k = 0; k < 5; k++) step(1, 0, "R2_R8 nickel run");
    check(vend === 1'b1, "R3", "vend at 25", int'(vend), 1);
    check(seg === 7'b0010010, "R8", "count 5 in vend", int'(seg), 'h12);
    step(0, 0, "R4 after vend");
    check(seg === 7'b1000000, "R4", "count cleared", int'(seg), 'h40);
    step(0, 0, "R4 pulse one cycle");
  endtask

  task automatic t_idle_hold();
    step(0, 1, "R2 dime");
    for (int k = 0; k < 4; k++) step(0, 0, "R2 hold");
    step(0, 1, "R2 dime");
    step(1, 0, "R3 nickel to 25");
    step(0, 0, "R4 back home");
  endtask

  task automatic t_overpay();
    for (int k = 0; k < 4; k++) step(1, 0, "R2 to 20");
    step(0, 1, "R3 dime to 30");
    check(vend === 1'b1, "R3", "overpay vends", int'(vend), 1);
    step(0, 0, "R4 overpay cleared");
    step(0, 1, "R3 dime");
    step(0, 1, "R3 dime");
    step(0, 1, "R3 dime to 30");
    step(0, 0, "R4 home");
  endtask

  task automatic t_both();
    step(1, 1, "R5 both");
    check(seg === 7'b1111001, "R5", "one coin", int'(seg), 'h79);
    step(0, 1, "R5 dime");
    step(1, 0, "R5 nickel to 25");
    check(vend === 1'b1, "R5", "dime valued 10", int'(vend), 1);
    step(0, 0, "R5 home");
  endtask

  task automatic t_coin_in_vend();
    step(0, 1, "R6 dime");
    step(0, 1, "R6 dime");
    step(1, 0, "R6 nickel to 25");
    step(0, 1, "R6 dime in vend");
    check(seg === 7'b1000000, "R6", "ignored coin", int'(seg), 'h40);
    step(1, 0, "R6 nickel in");
    check(seg === 7'b1111001, "R6", "fresh count", int'(seg), 'h79);
  endtask

  task automatic t_mid_clear();
    step(0, 1, "R1 dime");
    t_clear("R1 mid credit clear");
    step(1, 0, "R1 nickel after clear");
    step(0, 1, "R1 dime");
    step(0, 1, "R1 dime to 25");
    check(vend === 1'b1, "R1", "credit was zeroed", int'(vend), 1);
    step(0, 0, "R1 home");
  endtask

  initial begin
    #1;
    compare("R1 reset state");
    @(negedge clk);
    arst_n = 1'b1;
    step(0, 0, "R1 idle");
    // The scenarios below visit every state of the one-hot register (R9).
    t_five_nickels();
    t_idle_hold();
    t_overpay();
    t_both();
    t_coin_in_vend();
    t_mid_clear();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule